// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This block is a purely combinational corrector for packed binary-coded decimal arithmetic. An 8-bit accumulator that holds the raw binary sum or difference of two packed-BCD operands enters the block together with the flag byte that the preceding add or subtract produced. The block returns the accumulator corrected back to two valid decimal digits, plus a rebuilt flag byte.

Three incoming flags steer the correction: the subtract flag, the half-carry flag and the carry flag. Each digit is corrected by six when its own trigger condition holds. An add and a subtract use different triggers and produce the half-carry in different ways. The carry may be raised by the correction but is never lowered. The unit holds no state. The surrounding datapath registers its outputs and decides when they are used.

Flag byte layout, for both input and output: bit 7 sign, bit 6 zero, bit 5 copy of result bit 5, bit 4 half-carry, bit 3 copy of result bit 3, bit 2 parity, bit 1 subtract, bit 0 carry.

Top module: `bcd_adjust_unit`

## Requirements
- R1: When the subtract flag (bit 1) is 0 and either the half-carry flag (bit 4) is 1 or the low nibble of `acc_in` is above 9, the block adds 6 to the accumulator. This is the low-digit add correction.
- R2: After the R1 step in add mode, the block adds 0x60 when the carry flag (bit 0) is 1 or the partly corrected 9-bit value is 0xA0 or more. The low 8 bits of the sum go to `acc_out`.
- R3: In add mode, the output half-carry (bit 4) is 1 exactly when the low nibble of `acc_in` is above 9.
- R4: When the subtract flag is 1, the block subtracts 6 if the half-carry flag is 1 or the low nibble is above 9. It also subtracts 0x60 if the carry flag is 1 or `acc_in` is above 0x99. The result wraps modulo 256.
- R5: In subtract mode, the output half-carry equals the input half-carry when the low nibble of `acc_in` is 5 or less, and is 0 otherwise.
- R6: The output carry (bit 0) is the input carry ORed with the correction carry. In add mode the correction carry is bit 8 of the corrected sum. In subtract mode it is set when `acc_in` is above 0x99. An input carry of 1 always gives an output carry of 1.
- R7: The output subtract flag equals the input subtract flag. Input flag bits 7, 6, 5, 3 and 2 have no effect on either output.
- R8: In the output flag byte, bit 7 is `acc_out` bit 7, bit 5 is `acc_out` bit 5, and bit 3 is `acc_out` bit 3. Bit 6 is 1 exactly when `acc_out` is zero.
- R9: Output bit 2 is 1 exactly when `acc_out` has an even number of set bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_in | input | 8 | Raw accumulator after the binary add or subtract |
| flags_in | input | 8 | Flag byte from that operation (subtract, half-carry and carry are used) |
| acc_out | output | 8 | Decimal-corrected accumulator |
| flags_out | output | 8 | Rebuilt flag byte |

## Verification
The low-digit and high-digit corrections can both act in one evaluation. The case that matters most is when the low correction's +6 ripples into the high digit and by itself pushes that digit past 9, as with 0x9A in add mode. A subtract can likewise combine a held half-carry with a low correction and a forced high correction. The bench provokes all of these by sweeping every accumulator value against every subtract, half-carry and carry combination. It does this twice, once with the ignored flag bits cleared and once with them set. Every output field is judged against an arithmetic model of the requirements. Directed vectors pin the ripple and hold cases to literal values.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  // Flag byte, most significant field first; positions are decoded by neighbours.
  typedef struct packed {
    logic sign;
    logic zero;
    logic copy5;
    logic half;
    logic copy3;
    logic parity;
    logic subtr;
    logic carry;
  } flag_t;

  localparam int FLAG_W = $bits(flag_t);
  localparam int DIGIT_MAX = 9;
  localparam int STEP = 6;
endpackage

// File: rtl/bcd_low_fix.sv
module bcd_low_fix
  import bcd_adj_pkg::*;
#(
  parameter int DIGIT_W  = 4,
  parameter int KEEP_MAX = 5
) (
  input  logic [DIGIT_W-1:0] low_digit,
  input  logic               sub_mode,
  input  logic               half_in,
  output logic               low_fix,
  output logic               half_out
);
  logic digit_over;

  always_comb begin
    digit_over = (low_digit > DIGIT_W'(DIGIT_MAX));
    low_fix    = half_in | digit_over;
    if (sub_mode) begin
      half_out = half_in & (low_digit <= DIGIT_W'(KEEP_MAX));
    end else begin
      half_out = digit_over;
    end
  end
endmodule

// File: rtl/bcd_high_fix.sv
module bcd_high_fix
  import bcd_adj_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [2*DIGIT_W-1:0] acc_in,
  input  logic                 sub_mode,
  input  logic                 carry_in,
  input  logic                 low_fix,
  output logic [2*DIGIT_W-1:0] acc_out,
  output logic                 carry_out
);
  localparam int W = 2 * DIGIT_W;
  localparam logic [W:0] LOW_STEP  = (W+1)'(STEP);
  localparam logic [W:0] HIGH_STEP = (W+1)'(STEP) << DIGIT_W;
  localparam logic [W-1:0] BCD_TOP = (W'(DIGIT_MAX) << DIGIT_W) | W'(DIGIT_MAX);

  logic [W:0] stage;
  logic [W:0] total;
  logic       high_fix;

  always_comb begin
    if (sub_mode) begin
      stage     = {1'b0, acc_in} - (low_fix ? LOW_STEP : '0);
      high_fix  = carry_in | (acc_in > BCD_TOP);
      total     = stage - (high_fix ? HIGH_STEP : '0);
      carry_out = carry_in | high_fix;
    end else begin
      stage     = {1'b0, acc_in} + (low_fix ? LOW_STEP : '0);
      high_fix  = carry_in | (stage[W:DIGIT_W] > (DIGIT_W+1)'(DIGIT_MAX));
      total     = stage + (high_fix ? HIGH_STEP : '0);
      carry_out = carry_in | total[W];
    end
    acc_out = total[W-1:0];
  end
endmodule

// File: rtl/bcd_flag_pack.sv
module bcd_flag_pack
  import bcd_adj_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] result,
  input  logic         half,
  input  logic         subtr,
  input  logic         carry,
  output flag_t        flags
);
  always_comb begin
    flags.sign   = result[W-1];
    flags.zero   = (result == '0);
    flags.copy5  = result[5];
    flags.half   = half;
    flags.copy3  = result[3];
    flags.parity = ~^result;
    flags.subtr  = subtr;
    flags.carry  = carry;
  end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [2*DIGIT_W-1:0] acc_in,
  input  logic [7:0]           flags_in,
  output logic [2*DIGIT_W-1:0] acc_out,
  output logic [7:0]           flags_out
);
  localparam int W = 2 * DIGIT_W;

  flag_t        fin;
  flag_t        fout;
  logic         low_fix;
  logic         half_new;
  logic         carry_new;
  logic [W-1:0] result;

  assign fin = flag_t'(flags_in);

  bcd_low_fix #(.DIGIT_W(DIGIT_W)) u_low (
    .low_digit (acc_in[DIGIT_W-1:0]),
    .sub_mode  (fin.subtr),
    .half_in   (fin.half),
    .low_fix   (low_fix),
    .half_out  (half_new)
  );

  bcd_high_fix #(.DIGIT_W(DIGIT_W)) u_high (
    .acc_in    (acc_in),
    .sub_mode  (fin.subtr),
    .carry_in  (fin.carry),
    .low_fix   (low_fix),
    .acc_out   (result),
    .carry_out (carry_new)
  );

  bcd_flag_pack #(.W(W)) u_flags (
    .result (result),
    .half   (half_new),
    .subtr  (fin.subtr),
    .carry  (carry_new),
    .flags  (fout)
  );

  assign acc_out   = result;
  assign flags_out = fout;

  always_comb begin
    // R6
    carry_keep_chk: assert (!fin.carry || fout.carry)
      else $error("carry cleared by adjust");
    // R3
    add_half_low_chk: assert (fin.subtr || !fout.half || (result[DIGIT_W-1:0] < DIGIT_W'(STEP)))
      else $error("add half-carry without low wrap");
    // R5
    sub_half_hold_chk: assert (!fin.subtr || !fout.half || fin.half)
      else $error("subtract raised half-carry");
    // R4
    sub_idle_chk: assert (!(fin.subtr && !fin.half && !fin.carry &&
                            acc_in[DIGIT_W-1:0] <= DIGIT_W'(DIGIT_MAX) &&
                            acc_in[W-1:DIGIT_W] <= DIGIT_W'(DIGIT_MAX)) || (result == acc_in))
      else $error("valid BCD altered by subtract adjust");
    // R2
    add_idle_chk: assert (!(!fin.subtr && !fin.half && !fin.carry &&
                            acc_in[DIGIT_W-1:0] <= DIGIT_W'(DIGIT_MAX) &&
                            acc_in[W-1:DIGIT_W] <= DIGIT_W'(DIGIT_MAX)) || (result == acc_in))
      else $error("valid BCD altered by add adjust");
    // R9
    zero_parity_chk: assert (!fout.zero || fout.parity)
      else $error("zero result with odd parity");
  end
endmodule

// File: tb/bcd_adjust_unit_tb.sv
module bcd_adjust_unit_tb;
  logic       clk;
  logic [7:0] acc_in;
  logic [7:0] flags_in;
  logic [7:0] acc_out;
  logic [7:0] flags_out;
  int         total;
  int         bad;
  bit         done;

  bcd_adjust_unit u_dut (
    .acc_in    (acc_in),
    .flags_in  (flags_in),
    .acc_out   (acc_out),
    .flags_out (flags_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp, input int a, input int f);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s acc_in=%02h flags_in=%02h actual=%02h expected=%02h", tag, a, f, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] a, input logic [7:0] f,
                                output logic [7:0] ea, output logic [7:0] ef);
    logic n, h, c, nh, nc, lowadj, hiadj;
    int t;
    n = f[1]; h = f[4]; c = f[0];
    lowadj = h | (a[3:0] > 9);
    if (!n) begin
      t = int'(a) + (lowadj ? 6 : 0);
      hiadj = c | (t >= 'hA0);
      t = t + (hiadj ? 'h60 : 0);
      nc = c | (t > 255);
      nh = (a[3:0] > 9);
    end else begin
      t = int'(a) - (lowadj ? 6 : 0);
      hiadj = c | (a > 8'h99);
      t = t - (hiadj ? 'h60 : 0);
      nc = c | (a > 8'h99);
      nh = h & (a[3:0] <= 5);
    end
    ea = t[7:0];
    ef = {ea[7], (ea == 8'h00), ea[5], nh, ea[3], ~^ea, n, nc};
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] f);
    @(negedge clk);
    acc_in = a;
    flags_in = f;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] ea, ef;
    total = 0; bad = 0; done = 0;
    acc_in = 8'h00; flags_in = 8'h00;

    // Directed corner cases
    apply(8'h0A, 8'h00);
    chk("R1 low fix", acc_out, 8'h10, 8'h0A, 8'h00);
    chk("R3 half", flags_out[4], 1, 8'h0A, 8'h00);
    apply(8'h9A, 8'h00);
    chk("R2 ripple", acc_out, 8'h00, 8'h9A, 8'h00);
    chk("R6 carry out", flags_out[0], 1, 8'h9A, 8'h00);
    chk("R8 zero", flags_out[6], 1, 8'h9A, 8'h00);
    apply(8'h0F, 8'h02);
    chk("R4 sub low", acc_out, 8'h09, 8'h0F, 8'h02);
    apply(8'h13, 8'h12);
    chk("R4 sub half", acc_out, 8'h0D, 8'h13, 8'h12);
    chk("R5 half hold", flags_out[4], 1, 8'h13, 8'h12);
    apply(8'h45, 8'h03);
    chk("R4 sub carry", acc_out, 8'hE5, 8'h45, 8'h03);
    chk("R6 carry kept", flags_out[0], 1, 8'h45, 8'h03);

    // Exhaustive sweep, ignored flag bits clear then set
    for (int m = 0; m < 2; m++) begin
      for (int fl = 0; fl < 8; fl++) begin
        for (int a = 0; a < 256; a++) begin
          logic [7:0] f;
          f = (m == 1) ? 8'hEC : 8'h00;
          f[1] = fl[0];
          f[4] = fl[1];
          f[0] = fl[2];
          apply(a[7:0], f);
          model(a[7:0], f, ea, ef);
          chk(fl[0] ? "R4 acc" : "R1/R2 acc", acc_out, ea, a, f);
          chk(fl[0] ? "R5 half" : "R3 half", flags_out[4], ef[4], a, f);
          chk("R6 carry", flags_out[0], ef[0], a, f);
          chk("R7 subtract kept", flags_out[1], ef[1], a, f);
          chk("R8 sign/zero/copies", {flags_out[7:5], flags_out[3]},
              {ef[7:5], ef[3]}, a, f);
          chk("R9 parity", flags_out[2], ef[2], a, f);
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule